// File: doc/BRIEF.md
# Thread Slot Scheduler

The scheduler picks, on every clock cycle, which of eight hardware threads may issue one instruction. The choice comes from a programmable slot table of 64 entries that is read one entry per cycle, in order, and wraps after a programmable number of entries. A thread that must run more often is simply listed in more entries. When the listed thread has nothing to do, its slot is lost: the table order is fixed and no other thread is moved into the gap.

A branch misprediction upstream can open a delay slot. That slot is offered only to threads flagged as non-real-time, chosen in round-robin order among those that are ready. The real-time schedule is never pulled forward. If no non-real-time thread is ready, the cycle is reported as a NOP. Table entries and the schedule length can be rewritten while the scheduler runs. A new length waits for the next return to entry 0.

Top module: `thread_slot_sched`

## Requirements
- R1: A synchronous reset sets the read position to entry 0, the active and pending lengths to 64, and drives `issue_valid` and `issue_nop` low. Both stay low in the first cycle after reset. The result for entry 0 appears in the second cycle after reset.
- R2: One table entry is consumed per cycle, in ascending index order. The outcome for the entry read at edge n, together with the thread inputs sampled at edge n+1, is driven from edge n+1 on.
- R3: The read position returns to entry 0 after entry L-1, where L is the active length. A length write with a value of 0 or above 64 is ignored.
- R4: A valid length write is held as pending. It becomes the active length only at the edge where the read position wraps to entry 0.
- R5: A table entry has a valid bit (`tbl_wvalid`) and a 3-bit thread number (`tbl_wtid`). A valid entry whose thread has its `thread_ready` bit set gives `issue_valid`=1 and `issue_tid` equal to that thread number.
- R6: An invalid entry, or one whose thread is not ready, gives `issue_nop`=1. No other ready thread is put in its place.
- R7: When `slot_open` is high, the table entry of that cycle is dropped. A thread whose bit is set in both `thread_ready` and `nrt_mask` is issued, and the read position still advances by one.
- R8: When `slot_open` is high and no thread is set in both `thread_ready` and `nrt_mask`, the cycle gives `issue_nop`=1.
- R9: Open slots are granted round-robin. The search starts at a pointer that resets to thread 0 and moves to one past each thread granted an open slot. Issues taken from the table do not move the pointer.
- R10: A table write to the entry being read at the same edge does not change that read. The new contents are issued from the next pass on.
- R11: `issue_valid` and `issue_nop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 6 | Table entry index to write |
| tbl_wvalid | input | 1 | Valid bit of the written entry |
| tbl_wtid | input | 3 | Thread number of the written entry |
| len_we | input | 1 | Length write strobe |
| len_wval | input | 7 | New schedule length, 1 to 64 |
| thread_ready | input | 8 | Per-thread has-work flags |
| nrt_mask | input | 8 | Per-thread non-real-time flags |
| slot_open | input | 1 | Delay slot opened by a misprediction |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_nop | output | 1 | The slot is consumed without an issue |
| issue_tid | output | 3 | Issuing thread number, 0 when not issuing |

## Verification
On every cycle, the assertions check that the read position steps by one or wraps exactly at the active length, and that the length changes only on a return to entry 0. They also check that an issued thread was ready, that an open slot went to a ready non-real-time thread or became a NOP, and that the two outcome flags are exclusive. Only the bench scenarios can show what is issued and in what order: the sequence of table contents, the round-robin rotation across successive open slots, and that out-of-range lengths are ignored. The same holds for the delayed take-up of a new length and the old-value result of a write that collides with a read.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int DEF_THREADS = 8;
  localparam int DEF_DEPTH   = 64;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_TABLE,
    SLOT_FILL,
    SLOT_EMPTY
  } slot_kind_e;
endpackage

// File: rtl/tss_slot_ram.sv
module tss_slot_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-before-write: a colliding read returns the stored word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tss_slot_ptr.sv
module tss_slot_ptr #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wval,
  output logic [IDX_W-1:0] ptr,
  output logic [LEN_W-1:0] len_cur
);
  logic [LEN_W-1:0] len_pend;
  logic             len_ok;
  logic             at_last;

  assign len_ok  = (len_wval != '0) && (len_wval <= LEN_W'(DEPTH));
  assign at_last = (LEN_W'(ptr) == (len_cur - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      len_cur  <= LEN_W'(DEPTH);
      len_pend <= LEN_W'(DEPTH);
    end else begin
      if (len_we && len_ok) len_pend <= len_wval;
      if (at_last) begin
        ptr     <= '0;
        len_cur <= len_pend;
      end else begin
        ptr <= ptr + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/tss_nrt_arb.sv
module tss_nrt_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_id
);
  logic [IW-1:0] rr_q;

  function automatic int wrap_idx(int base, int off);
    int s;
    s = base + off;
    if (s >= N) s = s - N;
    return s;
  endfunction

  // scan from farthest to nearest so the nearest requester wins
  always_comb begin
    gnt_vld = 1'b0;
    gnt_id  = '0;
    for (int off = N - 1; off >= 0; off--) begin
      if (req[wrap_idx(int'(rr_q), off)]) begin
        gnt_vld = 1'b1;
        gnt_id  = IW'(wrap_idx(int'(rr_q), off));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && gnt_vld) begin
      rr_q <= (gnt_id == IW'(N - 1)) ? '0 : gnt_id + IW'(1);
    end
  end
endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched
  import tss_pkg::*;
#(
  parameter int NUM_THREADS = DEF_THREADS,
  parameter int TABLE_DEPTH = DEF_DEPTH,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int IDX_W = $clog2(TABLE_DEPTH),
  localparam int LEN_W = $clog2(TABLE_DEPTH + 1),
  localparam int ENT_W = TID_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_waddr,
  input  logic                   tbl_wvalid,
  input  logic [TID_W-1:0]       tbl_wtid,
  input  logic                   len_we,
  input  logic [LEN_W-1:0]       len_wval,
  input  logic [NUM_THREADS-1:0] thread_ready,
  input  logic [NUM_THREADS-1:0] nrt_mask,
  input  logic                   slot_open,
  output logic                   issue_valid,
  output logic                   issue_nop,
  output logic [TID_W-1:0]       issue_tid
);
  logic [IDX_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_cur;
  logic [ENT_W-1:0] rd_word;
  logic             rd_vld_q;
  logic             ent_valid;
  logic [TID_W-1:0] ent_tid;
  logic             gnt_vld;
  logic [TID_W-1:0] gnt_id;
  slot_kind_e       kind;
  logic [TID_W-1:0] nxt_tid;

  tss_slot_ptr #(.DEPTH(TABLE_DEPTH)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .len_we   (len_we),
    .len_wval (len_wval),
    .ptr      (ptr_q),
    .len_cur  (len_cur)
  );

  tss_slot_ram #(.DEPTH(TABLE_DEPTH), .WIDTH(ENT_W)) u_ram (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata ({tbl_wvalid, tbl_wtid}),
    .raddr (ptr_q),
    .rdata (rd_word)
  );

  tss_nrt_arb #(.N(NUM_THREADS)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (thread_ready & nrt_mask),
    .take    (kind == SLOT_FILL),
    .gnt_vld (gnt_vld),
    .gnt_id  (gnt_id)
  );

  assign ent_valid = rd_word[TID_W];
  assign ent_tid   = rd_word[TID_W-1:0];

  // the table word lags the pointer by one edge
  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= 1'b1;
  end

  always_comb begin
    kind    = SLOT_IDLE;
    nxt_tid = '0;
    if (rd_vld_q) begin
      if (slot_open) begin
        if (gnt_vld) begin
          kind    = SLOT_FILL;
          nxt_tid = gnt_id;
        end else begin
          kind = SLOT_EMPTY;
        end
      end else if (ent_valid && thread_ready[ent_tid]) begin
        kind    = SLOT_TABLE;
        nxt_tid = ent_tid;
      end else begin
        kind = SLOT_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_nop   <= 1'b0;
      issue_tid   <= '0;
    end else begin
      issue_valid <= (kind == SLOT_TABLE) || (kind == SLOT_FILL);
      issue_nop   <= (kind == SLOT_EMPTY);
      issue_tid   <= nxt_tid;
    end
  end
endmodule

// File: rtl/tss_sched_chk.sv
module tss_sched_chk #(
  parameter int NUM_THREADS = 8,
  parameter int TABLE_DEPTH = 64,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int IDX_W = $clog2(TABLE_DEPTH),
  localparam int LEN_W = $clog2(TABLE_DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [IDX_W-1:0]       ptr,
  input logic [LEN_W-1:0]       len_cur,
  input logic                   rd_vld,
  input logic [NUM_THREADS-1:0] thread_ready,
  input logic [NUM_THREADS-1:0] nrt_mask,
  input logic                   slot_open,
  input logic                   issue_valid,
  input logic                   issue_nop,
  input logic [TID_W-1:0]       issue_tid
);
  logic [NUM_THREADS-1:0] rdy_q;
  logic [NUM_THREADS-1:0] nrt_rdy_q;
  logic                   open_q;
  logic                   rdvld_q;

  always_ff @(posedge clk) begin
    rdy_q     <= thread_ready;
    nrt_rdy_q <= thread_ready & nrt_mask;
    open_q    <= slot_open;
    rdvld_q   <= rd_vld;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!issue_valid && !issue_nop));

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (LEN_W'(ptr) != len_cur - LEN_W'(1)) |=> (ptr == $past(ptr) + IDX_W'(1)));

  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (LEN_W'(ptr) == len_cur - LEN_W'(1)) |=> (ptr == '0));

  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    (LEN_W'(ptr) < len_cur) && (len_cur != '0) && (len_cur <= LEN_W'(TABLE_DEPTH)));

  a_r4_len_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(len_cur) |-> (ptr == '0));

  a_r6_issued_was_ready: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> rdy_q[issue_tid]);

  a_r7_fill_is_nrt: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && open_q) |-> nrt_rdy_q[issue_tid]);

  a_r8_nop_without_nrt: assert property (@(posedge clk) disable iff (rst)
    (rdvld_q && open_q && (nrt_rdy_q == '0)) |-> issue_nop);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid && issue_nop));
endmodule

bind thread_slot_sched tss_sched_chk #(
  .NUM_THREADS (NUM_THREADS),
  .TABLE_DEPTH (TABLE_DEPTH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ptr          (ptr_q),
  .len_cur      (len_cur),
  .rd_vld       (rd_vld_q),
  .thread_ready (thread_ready),
  .nrt_mask     (nrt_mask),
  .slot_open    (slot_open),
  .issue_valid  (issue_valid),
  .issue_nop    (issue_nop),
  .issue_tid    (issue_tid)
);

// File: tb/thread_slot_sched_bench.sv
module thread_slot_sched_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbl_we = 1'b0;
  logic [5:0] tbl_waddr = '0;
  logic       tbl_wvalid = 1'b0;
  logic [2:0] tbl_wtid = '0;
  logic       len_we = 1'b0;
  logic [6:0] len_wval = '0;
  logic [7:0] thread_ready = '0;
  logic [7:0] nrt_mask = '0;
  logic       slot_open = 1'b0;
  logic       issue_valid;
  logic       issue_nop;
  logic [2:0] issue_tid;

  int nchk = 0;
  int nfail = 0;
  int ncyc = 0;
  bit done = 1'b0;

  logic       log_v [256];
  logic       log_n [256];
  logic [2:0] log_t [256];

  always #4 clk = ~clk;

  thread_slot_sched u_thread_slot_sched (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wvalid(tbl_wvalid), .tbl_wtid(tbl_wtid), .len_we(len_we),
    .len_wval(len_wval), .thread_ready(thread_ready), .nrt_mask(nrt_mask),
    .slot_open(slot_open), .issue_valid(issue_valid), .issue_nop(issue_nop),
    .issue_tid(issue_tid)
  );

  always @(posedge clk) begin
    if (rst) ncyc <= 0;
    else     ncyc <= ncyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && ncyc < 256) begin
      log_v[ncyc] = issue_valid;
      log_n[ncyc] = issue_nop;
      log_t[ncyc] = issue_tid;
    end
  end

  typedef struct packed {
    logic [7:0] rdy;
    logic [7:0] nrt;
    logic       opn;
    logic       ev;
    logic       en;
    logic [2:0] tid;
    logic [3:0] req;
  } vec_t;

  // all table entries hold valid thread 5 during this walk
  localparam vec_t VEC [14] = '{
    '{8'h20, 8'h00, 1'b0, 1'b1, 1'b0, 3'd5, 4'd5},
    '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 4'd6},
    '{8'hDF, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 4'd6},
    '{8'hFF, 8'h81, 1'b1, 1'b1, 1'b0, 3'd0, 4'd7},
    '{8'hFF, 8'h81, 1'b1, 1'b1, 1'b0, 3'd7, 4'd9},
    '{8'hFF, 8'h81, 1'b1, 1'b1, 1'b0, 3'd0, 4'd9},
    '{8'h7F, 8'h81, 1'b1, 1'b1, 1'b0, 3'd0, 4'd7},
    '{8'h7E, 8'h81, 1'b1, 1'b0, 1'b1, 3'd0, 4'd8},
    '{8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 3'd0, 4'd8},
    '{8'hFF, 8'h0C, 1'b1, 1'b1, 1'b0, 3'd2, 4'd9},
    '{8'hFF, 8'h0C, 1'b1, 1'b1, 1'b0, 3'd3, 4'd9},
    '{8'hFF, 8'h0C, 1'b1, 1'b1, 1'b0, 3'd2, 4'd9},
    '{8'h20, 8'h20, 1'b0, 1'b1, 1'b0, 3'd5, 4'd5},
    '{8'hFF, 8'h30, 1'b1, 1'b1, 1'b0, 3'd4, 4'd9}
  };

  function automatic string tag_of(logic [3:0] r);
    case (r)
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // outcome packed as valid*100 + nop*10 + tid for printing
  function automatic int pack_out(logic v, logic n, logic [2:0] t);
    return int'(v) * 100 + int'(n) * 10 + int'(t);
  endfunction

  task automatic check_log(input int n, input logic ev, input logic en,
                           input logic [2:0] et, input string tag);
    check(log_v[n] == ev && log_n[n] == en && log_t[n] == et, tag,
          $sformatf("outcome at cycle %0d", n),
          pack_out(log_v[n], log_n[n], log_t[n]), pack_out(ev, en, et));
  endtask

  task automatic wait_cyc(input int k);
    while (ncyc < k) @(negedge clk);
  endtask

  // mode 0: all valid thread 5; mode 1: valid i%8; mode 2: as 1, entry 20 invalid
  task automatic do_reset(input int mode);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbl_we     = 1'b1;
      tbl_waddr  = 6'(i);
      tbl_wvalid = !(mode == 2 && i == 20);
      tbl_wtid   = (mode == 0) ? 3'd5 : (mode == 2 && i == 20) ? 3'd4 : 3'(i % 8);
    end
    @(negedge clk);
    tbl_we = 1'b0;
    check(!issue_valid && !issue_nop, "R1", "outputs held in reset",
          pack_out(issue_valid, issue_nop, issue_tid), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (R1 to R11 unfinished): actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    // vector walk, R5 to R9 and R11
    do_reset(0);
    @(negedge clk);
    check(!issue_valid && !issue_nop, "R1", "idle first cycle after reset",
          pack_out(issue_valid, issue_nop, issue_tid), 0);
    thread_ready = VEC[0].rdy;
    nrt_mask     = VEC[0].nrt;
    slot_open    = VEC[0].opn;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      check(issue_valid == VEC[i].ev && issue_nop == VEC[i].en &&
            issue_tid == VEC[i].tid && !(issue_valid && issue_nop),
            tag_of(VEC[i].req), $sformatf("vector %0d", i),
            pack_out(issue_valid, issue_nop, issue_tid),
            pack_out(VEC[i].ev, VEC[i].en, VEC[i].tid));
      if (i < 13) begin
        thread_ready = VEC[i+1].rdy;
        nrt_mask     = VEC[i+1].nrt;
        slot_open    = VEC[i+1].opn;
      end
    end
    thread_ready = 8'hFF;
    nrt_mask     = 8'h00;
    slot_open    = 1'b0;

    // table order, length update at wrap, ignored lengths: R2 R3 R4
    do_reset(1);
    wait_cyc(3);  len_we = 1'b1; len_wval = 7'd3;
    wait_cyc(4);  len_we = 1'b0;
    wait_cyc(10); len_we = 1'b1; len_wval = 7'd0;
    wait_cyc(11); len_we = 1'b0;
    wait_cyc(20); len_we = 1'b1; len_wval = 7'd65;
    wait_cyc(21); len_we = 1'b0;
    wait_cyc(72);
    check_log(2,  1'b1, 1'b0, 3'd0, "R1");
    check_log(9,  1'b1, 1'b0, 3'd7, "R2");
    check_log(5,  1'b1, 1'b0, 3'd3, "R4");
    check_log(65, 1'b1, 1'b0, 3'd7, "R2");
    check_log(66, 1'b1, 1'b0, 3'd0, "R4");
    check_log(68, 1'b1, 1'b0, 3'd2, "R3");
    check_log(69, 1'b1, 1'b0, 3'd0, "R3");
    check_log(71, 1'b1, 1'b0, 3'd2, "R3");

    // write colliding with read, invalid entry: R10 R6
    do_reset(2);
    wait_cyc(10);
    tbl_we = 1'b1; tbl_waddr = 6'd10; tbl_wvalid = 1'b1; tbl_wtid = 3'd6;
    wait_cyc(11);
    tbl_we = 1'b0;
    wait_cyc(78);
    check_log(12, 1'b1, 1'b0, 3'd2, "R10");
    check_log(76, 1'b1, 1'b0, 3'd6, "R10");
    check_log(22, 1'b0, 1'b1, 3'd0, "R6");
    check_log(21, 1'b1, 1'b0, 3'd3, "R2");

    // reset while running
    rst = 1'b1;
    @(negedge clk);
    check(!issue_valid && !issue_nop, "R1", "idle after mid-run reset",
          pack_out(issue_valid, issue_nop, issue_tid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule